// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block sits beside a descriptor-queue engine and decides when software should be told that work has finished. Instead of driving an interrupt line for every completed descriptor, it batches completions and sends one memory write, a message-signalled interrupt, to a programmable 48-bit address with a programmable 32-bit payload. Two conditions can trigger a message. The first is a count condition: the number of completed-but-unreleased descriptors has risen and has reached a programmed threshold. The second is an optional timeout that a completion asking for an interrupt starts, so a small batch is still reported after a bounded delay.

The queue engine supplies the current completed count, plus a one-cycle completion strobe with that descriptor's interrupt-request flag. Configuration arrives through a simple write-only register port. A message is presented as a valid/acknowledge transaction and is held stable until the fabric acknowledges it. Only one message can be outstanding at any time.

Top module: `irq_coalescer`

## Requirements
- R1: While reset is asserted and after it is released, `msg_valid` is 0 until a trigger condition occurs.
- R2: Count trigger. When `cmp_count` rises to a nonzero value that is greater than or equal to the count threshold, `msg_valid` goes high on the second rising clock edge after the new count is presented, and not on the first.
- R3: After a message has been acknowledged, no further message is sent while `cmp_count` does not rise and no new timeout expires.
- R4: The count threshold is written with `reg_sel` = 0, in `reg_wdata[14:0]`. When the timeout is disabled, a count below the threshold never produces a message.
- R5: Timeout trigger. The timeout is enabled by `reg_wdata[18]` of the `reg_sel` = 0 write, and its limit T is written with `reg_sel` = 1 in `reg_wdata[12:0]`. A completion strobe with `cmp_irq` = 1 that is sampled at edge E starts the timer, and `msg_valid` rises at edge E+T+1 even if the count is below the threshold.
- R6: A completion strobe with `cmp_irq` = 0 does not start the timer.
- R7: While `msg_valid` is high and `msg_ack` is low, `msg_valid`, `msg_addr` and `msg_data` hold their values. The edge that samples `msg_ack` high drops `msg_valid`, and no second message overlaps it.
- R8: `msg_addr` = {address-high field, address-low word}. The address-low word is written with `reg_sel` = 2 (all 32 bits), and the address-high field with `reg_sel` = 3 (`reg_wdata[15:0]`). `msg_data` is the payload written with `reg_sel` = 4. Both values are captured when the message is issued, so register writes during an outstanding message do not change it.
- R9: Two events can land in the same cycle as an issue. A count rise in the issue cycle stays pending, and a second message follows the acknowledgement. An interrupt-requesting completion in the issue cycle restarts the timer from zero, so a further timeout message follows T+1 edges later.
- R10: Issuing a message clears the timer, and the timer value seen in the cycle after an issue is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 control, 1 timeout, 2 address low, 3 address high, 4 payload |
| reg_wdata | input | 32 | Register write data |
| cmp_count | input | 15 | Current completed-but-unreleased descriptor count |
| cmp_valid | input | 1 | One-cycle strobe: a descriptor completed |
| cmp_irq | input | 1 | Completing descriptor requested an interrupt (qualified by cmp_valid) |
| msg_valid | output | 1 | Message write request pending |
| msg_addr | output | 48 | Message target address |
| msg_data | output | 32 | Message payload |
| msg_ack | input | 1 | Fabric accepts the pending message |

## Verification
Two functions can fall in the same cycle: issuing a message, and the arrival of a new completion, which can be a count increase, an interrupt-requesting strobe that restarts the timer, or both. The bench provokes this by timing the count step, or the strobe, so that it is sampled on exactly the edge where the message is issued. For a count step, that edge is the second edge after the count reaches the threshold. For a strobe, it is the edge where a running timeout expires. Correct handling is judged from the outputs. A count rise must produce a second message on the edge after the acknowledgement has cleared the first. A restarted timer must produce a second message exactly T+1 edges after the coinciding strobe, while losing the event would leave the line quiet.

// File: rtl/coal_pkg.sv
package coal_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_TMO   = 3'd1,
    SEL_ALO   = 3'd2,
    SEL_AHI   = 3'd3,
    SEL_DATA  = 3'd4
  } reg_sel_e;

  localparam int REG_W = 32;

endpackage

// File: rtl/coal_regs.sv
module coal_regs
  import coal_pkg::*;
#(
  parameter int CNT_W   = 15,
  parameter int TMO_W   = 13,
  parameter int AHI_W   = 16,
  parameter int DW      = 32,
  parameter int TEN_BIT = 18,
  localparam int AW     = REG_W + AHI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       sel,
  input  logic [REG_W-1:0] wdata,
  output logic [CNT_W-1:0] thr,
  output logic             tmr_en,
  output logic [TMO_W-1:0] tmo,
  output logic [AW-1:0]    addr,
  output logic [DW-1:0]    pay
);

  logic ld_ctrl, ld_tmo, ld_alo, ld_ahi, ld_data;
  logic unused_wdata;

  assign unused_wdata = ^wdata;

  always_comb begin
    ld_ctrl = we && (sel == SEL_CTRL);
    ld_tmo  = we && (sel == SEL_TMO);
    ld_alo  = we && (sel == SEL_ALO);
    ld_ahi  = we && (sel == SEL_AHI);
    ld_data = we && (sel == SEL_DATA);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr    <= '0;
      tmr_en <= 1'b0;
    end else if (ld_ctrl) begin
      thr    <= wdata[CNT_W-1:0];
      tmr_en <= wdata[TEN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmo <= '0;
    else if (ld_tmo) tmo <= wdata[TMO_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr[REG_W-1:0] <= '0;
    else if (ld_alo) addr[REG_W-1:0] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr[AW-1:REG_W] <= '0;
    else if (ld_ahi) addr[AW-1:REG_W] <= wdata[AHI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pay <= '0;
    else if (ld_data) pay <= wdata[DW-1:0];
  end

endmodule

// File: rtl/coal_trigger.sv
module coal_trigger #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] thr,
  input  logic             issue,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cnt_hit
);

  logic fresh_q, fresh_d;
  logic rise;

  always_comb begin
    rise = (count > cnt_q);
    if (rise)       fresh_d = 1'b1;
    else if (issue) fresh_d = 1'b0;
    else            fresh_d = fresh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fresh_q <= 1'b0;
    end else begin
      cnt_q   <= count;
      fresh_q <= fresh_d;
    end
  end

  assign cnt_hit = fresh_q && (cnt_q != '0) && (cnt_q >= thr);

endmodule

// File: rtl/coal_timer.sv
module coal_timer #(
  parameter int TMO_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             clear,
  input  logic [TMO_W-1:0] tmo,
  output logic             run_q,
  output logic [TMO_W-1:0] tcnt_q,
  output logic             hit
);

  logic             run_d;
  logic [TMO_W-1:0] tcnt_d;

  always_comb begin
    run_d  = run_q;
    tcnt_d = tcnt_q;
    if (start) begin
      run_d  = 1'b1;
      tcnt_d = '0;
    end else if (clear) begin
      run_d  = 1'b0;
      tcnt_d = '0;
    end else if (run_q && (tcnt_q < tmo)) begin
      tcnt_d = tcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      tcnt_q <= '0;
    end else begin
      run_q  <= run_d;
      tcnt_q <= tcnt_d;
    end
  end

  assign hit = run_q && (tcnt_q >= tmo);

endmodule

// File: rtl/coal_msg.sv
module coal_msg #(
  parameter int AW = 48,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  input  logic          ack,
  output logic          valid,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);

  logic valid_d;

  always_comb begin
    if (fire)             valid_d = 1'b1;
    else if (valid && ack) valid_d = 1'b0;
    else                  valid_d = valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      data <= '0;
    end else if (fire) begin
      addr <= addr_in;
      data <= data_in;
    end
  end

endmodule

// File: rtl/irq_coalescer.sv
module irq_coalescer #(
  parameter int CNT_W   = 15,
  parameter int TMO_W   = 13,
  parameter int AHI_W   = 16,
  parameter int DW      = 32,
  parameter int TEN_BIT = 18,
  localparam int AW     = coal_pkg::REG_W + AHI_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic [2:0]                 reg_sel,
  input  logic [coal_pkg::REG_W-1:0] reg_wdata,
  input  logic [CNT_W-1:0]           cmp_count,
  input  logic                       cmp_valid,
  input  logic                       cmp_irq,
  output logic                       msg_valid,
  output logic [AW-1:0]              msg_addr,
  output logic [DW-1:0]              msg_data,
  input  logic                       msg_ack
);

  logic [1:0]       rst_pipe;
  logic             rst_n_s;
  logic [CNT_W-1:0] thr;
  logic             tmr_en;
  logic [TMO_W-1:0] tmo;
  logic [AW-1:0]    cfg_addr;
  logic [DW-1:0]    cfg_pay;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_hit;
  logic             run_q;
  logic [TMO_W-1:0] tcnt_q;
  logic             tmr_hit;
  logic             tmr_start;
  logic             fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  always_comb begin
    tmr_start = cmp_valid && cmp_irq && tmr_en;
    fire      = !msg_valid && (cnt_hit || (tmr_en && tmr_hit));
  end

  coal_regs #(
    .CNT_W(CNT_W), .TMO_W(TMO_W), .AHI_W(AHI_W), .DW(DW), .TEN_BIT(TEN_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_s), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .thr(thr), .tmr_en(tmr_en), .tmo(tmo), .addr(cfg_addr), .pay(cfg_pay)
  );

  coal_trigger #(.CNT_W(CNT_W)) u_trig (
    .clk(clk), .rst_n(rst_n_s), .count(cmp_count), .thr(thr), .issue(fire),
    .cnt_q(cnt_q), .cnt_hit(cnt_hit)
  );

  coal_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk(clk), .rst_n(rst_n_s), .start(tmr_start), .clear(fire), .tmo(tmo),
    .run_q(run_q), .tcnt_q(tcnt_q), .hit(tmr_hit)
  );

  coal_msg #(.AW(AW), .DW(DW)) u_msg (
    .clk(clk), .rst_n(rst_n_s), .fire(fire), .addr_in(cfg_addr), .data_in(cfg_pay),
    .ack(msg_ack), .valid(msg_valid), .addr(msg_addr), .data(msg_data)
  );

endmodule

// File: rtl/irq_coalescer_chk.sv
module irq_coalescer_chk #(
  parameter int CNT_W = 15,
  parameter int TMO_W = 13,
  parameter int AW    = 48,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmp_valid,
  input logic             cmp_irq,
  input logic             msg_valid,
  input logic             msg_ack,
  input logic [AW-1:0]    msg_addr,
  input logic [DW-1:0]    msg_data,
  input logic             tmr_en,
  input logic [CNT_W-1:0] thr,
  input logic [CNT_W-1:0] cnt_q,
  input logic             run_q,
  input logic [TMO_W-1:0] tcnt_q
);

  a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ack) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  a_r7_drop_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ack) |=> !msg_valid);

  a_r4_count_only_at_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(msg_valid) && !$past(tmr_en)) |-> (($past(cnt_q) >= $past(thr)) && ($past(cnt_q) != '0)));

  a_r10_timer_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> (tcnt_q == '0));

  a_r6_start_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(cmp_valid && cmp_irq));

endmodule

bind irq_coalescer irq_coalescer_chk #(
  .CNT_W(CNT_W), .TMO_W(TMO_W), .AW(AW), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_irq(cmp_irq),
  .msg_valid(msg_valid), .msg_ack(msg_ack), .msg_addr(msg_addr), .msg_data(msg_data),
  .tmr_en(tmr_en), .thr(thr), .cnt_q(cnt_q), .run_q(run_q), .tcnt_q(tcnt_q)
);

// File: tb/irq_coalescer_test.sv
module irq_coalescer_test;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [14:0] cmp_count;
  logic        cmp_valid;
  logic        cmp_irq;
  logic        msg_valid;
  logic [47:0] msg_addr;
  logic [31:0] msg_data;
  logic        msg_ack;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] exp_data;
  localparam logic [47:0] EXP_ADDR = 48'h1234_DEAD_B000;

  irq_coalescer uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .cmp_count(cmp_count), .cmp_valid(cmp_valid), .cmp_irq(cmp_irq),
    .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data), .msg_ack(msg_ack)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    reg_we = 1; reg_sel = s; reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic ack_msg();
    msg_ack = 1;
    tick();
    msg_ack = 0;
    chk(msg_valid == 0, "R7 drop after ack", msg_valid, 0);
  endtask

  task automatic quiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      tick();
      chk(msg_valid == 0, req, msg_valid, 0);
    end
  endtask

  initial begin
    rst_n = 0; reg_we = 0; reg_sel = 0; reg_wdata = 0;
    cmp_count = 0; cmp_valid = 0; cmp_irq = 0; msg_ack = 0;
    repeat (3) tick();
    chk(msg_valid == 0, "R1 in reset", msg_valid, 0);
    rst_n = 1;
    quiet(4, "R1 after reset");

    wr(3'd2, 32'hDEAD_B000);
    wr(3'd3, 32'hFFFF_1234);
    exp_data = 32'hC0DE_0001;
    wr(3'd4, exp_data);

    // R2/R4/R7/R8: count threshold sweep, timer disabled
    for (int t = 1; t <= 5; t++) begin
      wr(3'd0, t | (32'h1 << 15));
      cmp_count = 0;
      tick(); tick();
      for (int c = 1; c <= t + 1; c++) begin
        cmp_count = c[14:0];
        tick();
        chk(msg_valid == 0, "R2 not on first edge", msg_valid, 0);
        tick();
        chk(msg_valid == (c >= t), "R2 R4 count trigger", msg_valid, (c >= t));
        if (msg_valid) begin
          chk(msg_addr == EXP_ADDR, "R8 address", msg_addr, EXP_ADDR);
          chk(msg_data == exp_data, "R8 payload", msg_data, exp_data);
          wr(3'd4, exp_data + 1);
          chk(msg_valid == 1, "R7 held", msg_valid, 1);
          chk(msg_data == exp_data, "R7 R8 payload stable", msg_data, exp_data);
          exp_data = exp_data + 1;
          ack_msg();
        end
      end
      quiet(5, "R3 no repeat");
    end

    // R5/R6/R10: timeout sweep with high count threshold
    wr(3'd0, 32'd100 | (32'h1 << 18));
    for (int tm = 0; tm <= 4; tm++) begin
      wr(3'd1, tm | 32'hFFFF_E000);
      cmp_count = 0;
      tick();
      cmp_count = 1; cmp_valid = 1; cmp_irq = 0;
      tick();
      cmp_valid = 0;
      quiet(tm + 4, "R6 no timer without request");
      cmp_count = 2; cmp_valid = 1; cmp_irq = 1;
      tick();
      cmp_valid = 0; cmp_irq = 0;
      for (int i = 0; i < tm; i++) begin
        chk(msg_valid == 0, "R5 early", msg_valid, 0);
        tick();
      end
      chk(msg_valid == 0, "R5 early", msg_valid, 0);
      tick();
      chk(msg_valid == 1, "R5 timeout fire", msg_valid, 1);
      ack_msg();
      quiet(tm + 4, "R10 timer cleared");
    end

    // R9: timer restart in issue cycle (T=3)
    wr(3'd1, 32'd3);
    cmp_count = 0;
    tick();
    cmp_count = 1; cmp_valid = 1; cmp_irq = 1;
    tick();
    cmp_valid = 0; cmp_irq = 0;
    tick(); tick(); tick();
    chk(msg_valid == 0, "R9 before first", msg_valid, 0);
    cmp_count = 2; cmp_valid = 1; cmp_irq = 1;
    tick();
    cmp_valid = 0; cmp_irq = 0;
    chk(msg_valid == 1, "R9 first timeout message", msg_valid, 1);
    ack_msg();
    tick();
    chk(msg_valid == 0, "R9 restart wait", msg_valid, 0);
    tick();
    chk(msg_valid == 0, "R9 restart wait", msg_valid, 0);
    tick();
    chk(msg_valid == 1, "R9 restarted timer message", msg_valid, 1);
    ack_msg();
    quiet(6, "R10 quiet after restart");

    // R9: count rise in issue cycle, timer disabled
    wr(3'd0, 32'd3);
    cmp_count = 2;
    tick(); tick();
    chk(msg_valid == 0, "R4 below threshold", msg_valid, 0);
    cmp_count = 3;
    tick();
    cmp_count = 4;
    tick();
    chk(msg_valid == 1, "R9 first count message", msg_valid, 1);
    ack_msg();
    tick();
    chk(msg_valid == 1, "R9 pending rise message", msg_valid, 1);
    ack_msg();
    quiet(6, "R3 quiet after pending");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule